// File: doc/BRIEF.md
# Address-Decoded On-Chip Memory Bank Array

This block connects a CPU bus with 16-bit data to a row of synchronous on-chip memory banks. There are several writable RAM banks and one read-only bank, and the read-only bank always takes the highest bank index. A 32-bit address is split into three fields: a word offset inside a bank, a bank index field above the offset, and the upper bits above that. A decoder turns the index field into one select line per bank. The CPU write strobe is ANDed with each bank's select, so a write can only reach the bank that owns the address. The read bus is the bitwise OR of all bank output registers. This works because every bank whose select is low applies a synchronous reset to its output register. That reset is driven by the inverted select, and it forces the register to zero. The reset does not block a write issued in the same cycle: a qualified write still lands in the array. This is why the write strobe has to be qualified per bank.

A parameter chooses between two decode modes. Full decode requires the upper address bits to be zero. Partial decode ignores them, so an upper address such as 0x1000_0000 aliases onto 0x0000_0000. The read-only bank has its clock enable tied to the inverse of its output reset, so it only reads when it is selected. A combinational `hit` output reports whether the present address falls in a decoded region.

With the default parameters the field positions are as follows. The bank offset is bits [9:0]. The index field is bits [11:10]: index 0 and index 1 are RAM, index 2 is the read-only bank, and index 3 is undecoded. Bits [31:12] are the upper bits.

Top module: `bram_bank_array`

## Requirements
- R1: A write with `we` high to an address in a RAM bank stores `wdata` at that bank's offset. A later read of the same address returns the stored word on `rdata` one clock after the address is presented.
- R2: `rdata` after a clock edge reflects the address present at that edge. When a write and a read hit the same RAM location in one cycle, `rdata` shows the word held before the write.
- R3: A write changes only the bank selected by its address. The same offset in every other bank keeps its contents.
- R4: Banks that are not selected drive zero from their output registers. `rdata` therefore equals the selected bank's word alone, for any mix of bank contents.
- R5: A read of the read-only bank (index field = 2) at offset `o` returns the low 16 bits of `o*0x9E37 + 0x1234`.
- R6: Writes to the read-only bank are dropped. Its contents read the same before and after any such write.
- R7: In full decode, an address with any nonzero bit in [31:12] gives `hit` = 0 and `rdata` = 0 on the following cycle, and a write to it is dropped.
- R8: `hit` is 1 exactly when the index field is 0, 1 or 2 and, in full decode, bits [31:12] are zero. Index field value 3 gives `hit` = 0 and `rdata` = 0 in both modes.
- R9: In partial decode, bits [31:12] are ignored. A write to 0x1000_0000 overwrites the word at 0x0000_0000, and `hit` is 1 for that address.
- R10: While `rst_n` is low, and on the first cycle after release that presents an undecoded address, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every bank |
| rst_n | input | 1 | Active-low synchronous clear of the bank output registers |
| addr | input | 32 | CPU word address |
| wdata | input | 16 | CPU write data |
| we | input | 1 | CPU write strobe, qualified per bank inside the block |
| rdata | output | 16 | Read data, the OR of all bank outputs, one cycle after the address |
| hit | output | 1 | High when `addr` falls in a decoded bank region |

## Verification
The bench builds two copies of the block with the default geometry: two 1K-word RAM banks plus the read-only bank. One copy uses full decode and the other uses partial decode. Both copies see the same bus stimulus. The full-decode copy shows that writes to addresses with nonzero upper bits are isolated and dropped. The partial-decode copy brings the aliasing hazard within reach: a write to 0x1000_0000 can be observed overwriting the word at 0x0000_0000. The random traffic mixes reads and writes across all four index values with occasional upper bits set, so the qualified write path and the OR read bus are exercised while banks alternate between selected and held in output reset.

// File: rtl/bram_bank_pkg.sv
package bram_bank_pkg;

   typedef enum logic {
      DECODE_FULL    = 1'b0,
      DECODE_PARTIAL = 1'b1
   } decode_e;

   // Fixed contents of the read-only bank, computed from the word offset.
   function automatic logic [31:0] rom_word(input logic [31:0] off);
      return off * 32'h0000_9E37 + 32'h0000_1234;
   endfunction

endpackage

// File: rtl/bram_addr_decode.sv
module bram_addr_decode
   import bram_bank_pkg::*;
#(
   parameter int      ADDR_W   = 32,
   parameter int      BANK_AW  = 10,
   parameter int      NUM_BANK = 3,
   parameter decode_e DECODE   = DECODE_FULL
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_BANK-1:0] sel,
   output logic                hit,
   output logic [BANK_AW-1:0]  off
);

   localparam int IDX_W = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
   localparam int UP_LO = BANK_AW + IDX_W;

   logic [IDX_W-1:0] idx;
   logic             upper_ok;

   assign idx = addr[BANK_AW +: IDX_W];
   assign off = addr[BANK_AW-1:0];

   generate
      if (DECODE == DECODE_FULL) begin : g_full
         assign upper_ok = (addr[ADDR_W-1:UP_LO] == '0);
      end else begin : g_partial
         logic unused_upper;
         assign unused_upper = ^addr[ADDR_W-1:UP_LO];
         assign upper_ok     = 1'b1;
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < NUM_BANK; i++) begin
         sel[i] = upper_ok && (idx == IDX_W'(i));
      end
      hit = |sel;
      assert ($onehot0(sel));                                                  // R8
      assert (!(hit && ({1'b0, idx} >= (IDX_W+1)'(NUM_BANK))));                // R8
   end

endmodule

// File: rtl/bram_bank.sv
module bram_bank
   import bram_bank_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int AW     = 10,
   parameter bit IS_ROM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              out_rst,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dout
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] rd_word;

   generate
      if (IS_ROM) begin : g_rom
         logic unused_wr;
         assign unused_wr = ^{we, wdata};
         assign rd_word   = DATA_W'(rom_word(32'(addr)));
      end else begin : g_ram
         logic [DATA_W-1:0] mem [DEPTH];
         // The write path ignores out_rst: a qualified write always stores.
         always_ff @(posedge clk) begin
            if (ce && we) mem[addr] <= wdata;
         end
         assign rd_word = mem[addr];
      end
   endgenerate

   // Output register: synchronous reset wins over the clock enable, read-first.
   always_ff @(posedge clk) begin
      if (!rst_n || out_rst) dout <= '0;
      else if (ce)           dout <= rd_word;
   end

   AST_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_rst |=> (dout == '0));                                               // R4

endmodule

// File: rtl/bram_read_or.sv
module bram_read_or #(
   parameter int DATA_W = 16,
   parameter int NUM    = 3
) (
   input  logic [NUM*DATA_W-1:0] words,
   output logic [DATA_W-1:0]     merged
);

   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM; i++) begin
         merged = merged | words[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/bram_bank_array.sv
module bram_bank_array
   import bram_bank_pkg::*;
#(
   parameter int      ADDR_W  = 32,
   parameter int      DATA_W  = 16,
   parameter int      BANK_AW = 10,
   parameter int      NUM_RAM = 2,
   parameter decode_e DECODE  = DECODE_FULL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] rdata,
   output logic              hit
);

   localparam int NUM_BANK = NUM_RAM + 1;
   localparam int ROM_IDX  = NUM_RAM;
   localparam int IDX_W    = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

   generate
      if (NUM_RAM < 1) begin : g_bad_num
         $error("bram_bank_array: NUM_RAM must be at least 1");
      end
      if (BANK_AW < 1 || BANK_AW > 14) begin : g_bad_aw
         $error("bram_bank_array: BANK_AW out of range");
      end
      if (BANK_AW + IDX_W >= ADDR_W) begin : g_bad_map
         $error("bram_bank_array: address too narrow for the bank map");
      end
   endgenerate

   logic [NUM_BANK-1:0]        bank_sel;
   logic [NUM_BANK-1:0]        bank_we;
   logic [NUM_BANK-1:0]        bank_rst;
   logic [BANK_AW-1:0]         bank_off;
   logic [NUM_BANK*DATA_W-1:0] bank_dout;

   bram_addr_decode #(
      .ADDR_W  (ADDR_W),
      .BANK_AW (BANK_AW),
      .NUM_BANK(NUM_BANK),
      .DECODE  (DECODE)
   ) i_decode (
      .addr(addr),
      .sel (bank_sel),
      .hit (hit),
      .off (bank_off)
   );

   genvar b;
   generate
      for (b = 0; b < NUM_BANK; b++) begin : g_bank
         logic bank_ce;
         assign bank_rst[b] = ~bank_sel[b];
         if (b == ROM_IDX) begin : g_rom_ctl
            assign bank_we[b] = 1'b0;
            assign bank_ce    = ~bank_rst[b];
         end else begin : g_ram_ctl
            assign bank_we[b] = we & bank_sel[b];
            assign bank_ce    = 1'b1;
         end

         bram_bank #(
            .DATA_W(DATA_W),
            .AW    (BANK_AW),
            .IS_ROM(b == ROM_IDX)
         ) i_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce     (bank_ce),
            .out_rst(bank_rst[b]),
            .we     (bank_we[b]),
            .addr   (bank_off),
            .wdata  (wdata),
            .dout   (bank_dout[b*DATA_W +: DATA_W])
         );

         AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            bank_we[b] |-> (bank_sel[b] && we));                               // R3
      end
   endgenerate

   bram_read_or #(
      .DATA_W(DATA_W),
      .NUM   (NUM_BANK)
   ) i_read_or (
      .words (bank_dout),
      .merged(rdata)
   );

   AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (rdata == '0));                                                 // R7

   AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (we && bank_sel[ROM_IDX]) |-> ($countones(bank_we) == 0));               // R6

endmodule

// File: tb/test_bram_bank_array.sv
module test_bram_bank_array;
   import bram_bank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] addr;
   logic [15:0] wdata;
   logic        we;
   logic [15:0] rdata_f, rdata_p;
   logic        hit_f, hit_p;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   bram_bank_array #(.DECODE(DECODE_FULL)) i_bram_bank_array (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
      .rdata(rdata_f), .hit(hit_f));

   bram_bank_array #(.DECODE(DECODE_PARTIAL)) i_bram_bank_array_alias (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
      .rdata(rdata_p), .hit(hit_p));

   logic [15:0] mf [0:1][0:1023];
   logic [15:0] mp [0:1][0:1023];

   bit          pend;
   string       ptag;
   logic [15:0] pexp_f, pexp_p;

   function automatic logic [15:0] rom_exp(input logic [9:0] o);
      logic [31:0] v;
      v = {22'd0, o} * 32'h9E37 + 32'h1234;
      return v[15:0];
   endfunction

   function automatic bit exp_hit(input bit full, input logic [31:0] a);
      if (a[11:10] == 2'd3) return 1'b0;
      if (full && a[31:12] != 20'd0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [15:0] model_read(input bit full, input logic [31:0] a);
      if (!exp_hit(full, a)) return 16'h0;
      if (a[11:10] == 2'd2)  return rom_exp(a[9:0]);
      return full ? mf[a[10]][a[9:0]] : mp[a[10]][a[9:0]];
   endfunction

   task automatic model_write(input logic [31:0] a, input logic [15:0] d);
      if (exp_hit(1'b1, a) && a[11:10] < 2'd2) mf[a[10]][a[9:0]] = d;
      if (exp_hit(1'b0, a) && a[11:10] < 2'd2) mp[a[10]][a[9:0]] = d;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic flush_pending();
      if (pend) begin
         check(ptag, "rdata full", rdata_f, pexp_f);
         check(ptag, "rdata alias", rdata_p, pexp_p);
      end
      pend = 1'b0;
   endtask

   // Drive one bus cycle; its read result is checked at the next negedge.
   task automatic op(input string tag, input logic [31:0] a,
                     input logic [15:0] d, input logic w);
      @(negedge clk);
      flush_pending();
      addr = a; wdata = d; we = w;
      pexp_f = model_read(1'b1, a);
      pexp_p = model_read(1'b0, a);
      ptag = tag; pend = 1'b1;
      #1;
      check(tag, "hit full", {15'd0, hit_f}, {15'd0, exp_hit(1'b1, a)});
      check(tag, "hit alias", {15'd0, hit_p}, {15'd0, exp_hit(1'b0, a)});
      if (w) model_write(a, d);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      pend = 1'b0;
      rst_n = 1'b0; we = 1'b0; wdata = 16'h0; addr = 32'h0000_0805;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", "rdata full in reset", rdata_f, 16'h0);
      check("R10", "rdata alias in reset", rdata_p, 16'h0);
      rst_n = 1'b1;
      op("R10", 32'h0000_0C00, 16'h0, 1'b0);

      // R1: prefill offsets 0..15 of both RAM banks, then read back
      for (int bk = 0; bk < 2; bk++)
         for (int o = 0; o < 16; o++)
            op("R1", {20'd0, 1'b0, bk[0], 6'd0, o[3:0]}, 16'($urandom), 1'b1);
      for (int bk = 0; bk < 2; bk++)
         for (int o = 0; o < 16; o++)
            op("R1", {20'd0, 1'b0, bk[0], 6'd0, o[3:0]}, 16'h0, 1'b0);

      // R2: write and read of one location in one cycle returns the old word
      op("R2", 32'h0000_0003, 16'hBEEF, 1'b1);
      op("R2", 32'h0000_0003, 16'h0, 1'b0);

      // R3: write bank 0 offset 7, bank 1 offset 7 keeps its word
      op("R3", 32'h0000_0007, 16'h5A5A, 1'b1);
      op("R3", 32'h0000_0407, 16'h0, 1'b0);
      op("R3", 32'h0000_0007, 16'h0, 1'b0);

      // R5 / R6: ROM reads, ROM write dropped
      op("R5", 32'h0000_0800, 16'h0, 1'b0);
      op("R5", 32'h0000_0BFF, 16'h0, 1'b0);
      op("R6", 32'h0000_0809, 16'hFFFF, 1'b1);
      op("R6", 32'h0000_0809, 16'h0, 1'b0);

      // R7 / R9: upper address bits set
      op("R7", 32'h1000_0000, 16'hAA55, 1'b1);
      op("R9", 32'h0000_0000, 16'h0, 1'b0);
      op("R7", 32'hFFFF_F401, 16'h0, 1'b0);

      // R8: undecoded index field
      op("R8", 32'h0000_0C05, 16'h1234, 1'b1);
      op("R8", 32'h0000_0005, 16'h0, 1'b0);
      op("R8", 32'h0000_0405, 16'h0, 1'b0);

      // R4: random mix across all regions
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a;
         a = {20'd0, 2'($urandom), 6'd0, 4'($urandom)};
         if ($urandom % 4 == 0) a[31:12] = 20'($urandom);
         op("R4", a, 16'($urandom), 1'($urandom));
      end

      @(negedge clk);
      flush_pending();
      finish_run();
   end

endmodule